// File: doc/BRIEF.md
# Masked-Tag Permission Lookaside Buffer

This block is a small, fully associative cache of protection-table entries, consulted on every load and store. Each entry holds a word tag plus a per-entry count of low tag bits to ignore. An entry therefore covers an aligned region of 2^n words, not a single page or a single word. The entry also carries the 2-bit permission that applies to the whole region. A lookup returns hit and permission in the same cycle. On a miss the block raises a walk request and keeps it up until the table walker writes the missing entry through the refill port.

Permission changes are handled by two mechanisms. The invalidate port takes a word address and its own ignore-count, and clears in one cycle every entry whose region overlaps the region it describes. A write to the table-base register marks a switch of the active protection domain, and it clears every entry.

Top module: `perm_lab`

## Requirements
- R1: After reset, no entry is valid. Every lookup misses, and `walk_req` is 0.
- R2: A lookup with `lk_valid` high hits only when a valid entry matches word address `lk_addr[31:2]`, and it then returns that entry's 2-bit permission unchanged. With `lk_valid` low, or on a miss, `lk_hit` is 0 and `lk_perm` is 2'b00.
- R3: An entry installed with ignore-count n matches every word in the aligned block of 2^n words that contains the refill word address, and no word outside that block. The refill word's low n bits play no part.
- R4: A lookup miss with `lk_valid` high and no request pending raises `walk_req` on the next cycle, with `walk_addr` equal to the missing byte address. Later misses leave `walk_addr` unchanged while the request is pending. A refill lowers `walk_req` on the following cycle.
- R5: A refill goes to the lowest-indexed invalid slot. When every slot is valid, the slot to overwrite is chosen round-robin, starting at slot 0 after reset, and the pointer moves on only when it is used.
- R6: An invalidate clears, in one cycle, every valid entry whose region overlaps the key region. The two are compared under the wider of the two ignore-counts. Entries that do not overlap stay valid. A refill in the same cycle survives the invalidate.
- R7: A pulse on `base_wr` clears every entry on the next cycle. A refill presented in the same cycle is discarded.
- R8: When more than one valid entry matches a lookup, the permission comes from the lowest-indexed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr | input | 1 | Table-base register write (domain switch), flushes all entries |
| lk_valid | input | 1 | Lookup strobe for a load or store |
| lk_addr | input | ADDR_W | Byte address looked up |
| lk_hit | output | 1 | A valid entry covers `lk_addr` |
| lk_perm | output | 2 | Permission of the selected entry, 00 on miss |
| walk_req | output | 1 | Table walk requested, held until refill |
| walk_addr | output | ADDR_W | Byte address of the miss being walked |
| rf_valid | input | 1 | Refill write strobe |
| rf_word | input | ADDR_W-2 | Word address of the walked entry |
| rf_ign | input | IGN_W | Number of low word-address bits ignored by the entry |
| rf_perm | input | 2 | Permission of the walked entry |
| inv_valid | input | 1 | Invalidate strobe |
| inv_word | input | ADDR_W-2 | Word address of the modified region |
| inv_ign | input | IGN_W | Number of low bits ignored by the invalidate key |

## Verification
On every cycle, the assertions check the walk-request handshake (it is set on a miss, held with a stable address, and dropped after a refill), that a flush empties the valid vector, that no entry flagged by an invalidate survives it, and that refill slot selection prefers a free slot. Only the directed scenarios can show the region coverage: which addresses fall inside or just outside a masked entry. The same holds for the order of round-robin eviction once the buffer is full, for lowest-slot priority between overlapping entries, and for the precedence between a flush, an invalidate and a refill that arrive in the same cycle.

// File: rtl/plb_pkg.sv
package plb_pkg;

  typedef logic [1:0] perm_t;

  localparam perm_t PERM_NONE = 2'b00;

endpackage

// File: rtl/plb_region_cmp.sv
module plb_region_cmp #(
  parameter int TAG_W = 30,
  parameter int IGN_W = 5
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [IGN_W-1:0] ent_ign,
  input  logic [TAG_W-1:0] look_tag,
  input  logic [TAG_W-1:0] key_tag,
  input  logic [IGN_W-1:0] key_ign,
  output logic             look_match,
  output logic             key_match
);

  logic [IGN_W-1:0] wide_ign;
  logic [TAG_W-1:0] look_mask;
  logic [TAG_W-1:0] key_mask;

  // Overlap of two aligned regions: compare under the coarser of the two
  assign wide_ign = (ent_ign > key_ign) ? ent_ign : key_ign;

  always_comb begin
    for (int b = 0; b < TAG_W; b++) begin
      look_mask[b] = (b >= int'(ent_ign));
      key_mask[b]  = (b >= int'(wide_ign));
    end
  end

  assign look_match = ent_valid && (((look_tag ^ ent_tag) & look_mask) == '0);
  assign key_match  = ent_valid && (((key_tag  ^ ent_tag) & key_mask)  == '0);

endmodule

// File: rtl/plb_slot_pick.sv
module plb_slot_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] vld,
  input  logic               take,
  output logic [IDX_W-1:0]   slot
);

  logic [IDX_W-1:0] rr_ptr;
  logic             free_found;

  // Lowest free slot wins, else the round-robin pointer
  always_comb begin
    free_found = 1'b0;
    slot       = rr_ptr;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_found = 1'b1;
        slot       = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (take && !free_found) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  // R5: a free slot is always preferred over eviction
  a_r5_free_first: assert property (@(posedge clk) disable iff (rst)
    (take && !(&vld)) |-> !vld[slot]);

  // R5: pointer never leaves the slot range
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (rst)
    rr_ptr <= IDX_W'(ENTRIES - 1));

endmodule

// File: rtl/perm_lab.sv
module perm_lab #(
  parameter int ADDR_W  = 32,
  parameter int IGN_W   = 5,
  parameter int ENTRIES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                base_wr,
  input  logic                lk_valid,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                lk_hit,
  output logic [1:0]          lk_perm,
  output logic                walk_req,
  output logic [ADDR_W-1:0]   walk_addr,
  input  logic                rf_valid,
  input  logic [ADDR_W-3:0]   rf_word,
  input  logic [IGN_W-1:0]    rf_ign,
  input  logic [1:0]          rf_perm,
  input  logic                inv_valid,
  input  logic [ADDR_W-3:0]   inv_word,
  input  logic [IGN_W-1:0]    inv_ign
);

  import plb_pkg::*;

  localparam int TAG_W = ADDR_W - 2;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   ent_tag  [ENTRIES];
  logic [IGN_W-1:0]   ent_ign  [ENTRIES];
  perm_t              ent_perm [ENTRIES];
  logic [ENTRIES-1:0] ent_vld;

  logic [ENTRIES-1:0] look_vec;
  logic [ENTRIES-1:0] inv_vec;
  logic [IDX_W-1:0]   fill_slot;
  logic               take;
  logic [TAG_W-1:0]   rf_tag_norm;
  logic               any_hit;
  perm_t              sel_perm;

  assign take = rf_valid && !base_wr;

  // Per-entry region comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    plb_region_cmp #(
      .TAG_W (TAG_W),
      .IGN_W (IGN_W)
    ) u_cmp (
      .ent_valid  (ent_vld[g]),
      .ent_tag    (ent_tag[g]),
      .ent_ign    (ent_ign[g]),
      .look_tag   (lk_addr[ADDR_W-1:2]),
      .key_tag    (inv_word),
      .key_ign    (inv_ign),
      .look_match (look_vec[g]),
      .key_match  (inv_vec[g])
    );
  end

  plb_slot_pick #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_pick (
    .clk  (clk),
    .rst  (rst),
    .vld  (ent_vld),
    .take (take),
    .slot (fill_slot)
  );

  // Lowest-indexed matching entry supplies the permission
  always_comb begin
    any_hit  = 1'b0;
    sel_perm = PERM_NONE;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (look_vec[i]) begin
        any_hit  = 1'b1;
        sel_perm = ent_perm[i];
      end
    end
  end

  assign lk_hit  = lk_valid && any_hit;
  assign lk_perm = lk_hit ? sel_perm : PERM_NONE;

  // Store the tag with its ignored bits cleared
  always_comb begin
    for (int b = 0; b < TAG_W; b++) begin
      rf_tag_norm[b] = rf_word[b] && (b >= int'(rf_ign));
    end
  end

  // Entry payload: written only on refill, no reset needed
  always_ff @(posedge clk) begin
    if (take) begin
      ent_tag[fill_slot]  <= rf_tag_norm;
      ent_ign[fill_slot]  <= rf_ign;
      ent_perm[fill_slot] <= rf_perm;
    end
  end

  // Valid bits: flush beats everything, refill beats invalidate
  always_ff @(posedge clk) begin
    if (rst || base_wr) begin
      ent_vld <= '0;
    end else begin
      if (inv_valid) begin
        ent_vld <= ent_vld & ~inv_vec;
      end
      if (rf_valid) begin
        ent_vld[fill_slot] <= 1'b1;
      end
    end
  end

  // Walk request handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      walk_req  <= 1'b0;
      walk_addr <= '0;
    end else if (rf_valid) begin
      walk_req <= 1'b0;
    end else if (lk_valid && !any_hit && !walk_req) begin
      walk_req  <= 1'b1;
      walk_addr <= lk_addr;
    end
  end

  // R2: a hit needs a request and a live entry
  a_r2_hit_needs_entry: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_valid && (|ent_vld)));

  // R4: miss raises the request
  a_r4_walk_set: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hit && !walk_req && !rf_valid) |=> walk_req);

  // R4: pending request and its address hold until refill
  a_r4_walk_hold: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !rf_valid) |=> (walk_req && $stable(walk_addr)));

  // R4: refill ends the request
  a_r4_walk_clear: assert property (@(posedge clk) disable iff (rst)
    rf_valid |=> !walk_req);

  // R6: nothing flagged by an invalidate survives it
  a_r6_inv_clears: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !rf_valid && !base_wr) |=> ((ent_vld & $past(inv_vec)) == '0));

  // R7: domain switch empties the buffer
  a_r7_flush: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (ent_vld == '0));

endmodule

// File: tb/perm_lab_tb.sv
`timescale 1ns/1ps
module perm_lab_tb;

  localparam int AW = 32;
  localparam int IW = 5;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          base_wr = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [1:0]    lk_perm;
  logic          walk_req;
  logic [AW-1:0] walk_addr;
  logic          rf_valid = 1'b0;
  logic [AW-3:0] rf_word = '0;
  logic [IW-1:0] rf_ign = '0;
  logic [1:0]    rf_perm = '0;
  logic          inv_valid = 1'b0;
  logic [AW-3:0] inv_word = '0;
  logic [IW-1:0] inv_ign = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  perm_lab #(.ADDR_W(AW), .IGN_W(IW), .ENTRIES(N)) u_dut (
    .clk(clk), .rst(rst), .base_wr(base_wr),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_perm(lk_perm),
    .walk_req(walk_req), .walk_addr(walk_addr),
    .rf_valid(rf_valid), .rf_word(rf_word), .rf_ign(rf_ign), .rf_perm(rf_perm),
    .inv_valid(inv_valid), .inv_word(inv_word), .inv_ign(inv_ign)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Combinational lookup, never clocked, so no walk is triggered
  task automatic look(input logic [31:0] a, input bit eh, input logic [1:0] ep,
                      input string req);
    @(negedge clk);
    lk_addr  = a;
    lk_valid = 1'b1;
    #1;
    check(lk_hit == eh, req, {31'd0, lk_hit}, {31'd0, eh});
    check(lk_perm == (eh ? ep : 2'b00), req, {30'd0, lk_perm}, {30'd0, (eh ? ep : 2'b00)});
    lk_valid = 1'b0;
  endtask

  task automatic refill(input logic [31:0] a, input logic [4:0] ig, input logic [1:0] p);
    @(negedge clk);
    rf_word = a[31:2]; rf_ign = ig; rf_perm = p; rf_valid = 1'b1;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic inval(input logic [31:0] a, input logic [4:0] ig);
    @(negedge clk);
    inv_word = a[31:2]; inv_ign = ig; inv_valid = 1'b1;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic t_reset();
    look(32'h0000_1000, 0, 2'b00, "R1");
    look(32'hFFFF_FFFC, 0, 2'b00, "R1");
    check(walk_req == 1'b0, "R1", {31'd0, walk_req}, 32'd0);
  endtask

  task automatic t_exact();
    refill(32'h0000_1000, 5'd0, 2'b01);
    look(32'h0000_1000, 1, 2'b01, "R2");
    look(32'h0000_1004, 0, 2'b00, "R2");
    @(negedge clk);
    lk_addr = 32'h0000_1000; lk_valid = 1'b0;
    #1;
    check(lk_hit == 1'b0 && lk_perm == 2'b00, "R2 idle", {29'd0, lk_hit, lk_perm}, 32'd0);
  endtask

  task automatic t_region();
    refill(32'h4000_0000, 5'd4, 2'b11);
    look(32'h4000_0000, 1, 2'b11, "R3 base");
    look(32'h4000_003C, 1, 2'b11, "R3 top");
    look(32'h4000_0040, 0, 2'b00, "R3 above");
    look(32'h3FFF_FFFC, 0, 2'b00, "R3 below");
    refill(32'h8000_0024, 5'd3, 2'b10);
    look(32'h8000_0020, 1, 2'b10, "R3 unaligned base");
    look(32'h8000_003C, 1, 2'b10, "R3 unaligned top");
    look(32'h8000_0040, 0, 2'b00, "R3 unaligned above");
  endtask

  task automatic t_walk();
    @(negedge clk);
    lk_addr = 32'h0000_2000; lk_valid = 1'b1;
    @(negedge clk);
    #1;
    check(walk_req == 1'b1, "R4 set", {31'd0, walk_req}, 32'd1);
    check(walk_addr == 32'h0000_2000, "R4 addr", walk_addr, 32'h0000_2000);
    lk_addr = 32'h0000_3000;
    @(negedge clk);
    #1;
    check(walk_addr == 32'h0000_2000, "R4 hold", walk_addr, 32'h0000_2000);
    check(walk_req == 1'b1, "R4 hold", {31'd0, walk_req}, 32'd1);
    lk_valid = 1'b0;
    refill(32'h0000_2000, 5'd0, 2'b01);
    #1;
    check(walk_req == 1'b0, "R4 clear", {31'd0, walk_req}, 32'd0);
    look(32'h0000_2000, 1, 2'b01, "R4 refilled");
  endtask

  task automatic t_repl();
    flush();
    for (int i = 0; i < N; i++) refill(32'h0001_0000 + i * 32'h100, 5'd0, 2'(i));
    for (int i = 0; i < N; i++) look(32'h0001_0000 + i * 32'h100, 1, 2'(i), "R5 fill");
    refill(32'h0000_9000, 5'd0, 2'b11);
    look(32'h0001_0000, 0, 2'b00, "R5 evict slot0");
    look(32'h0000_9000, 1, 2'b11, "R5 new");
    refill(32'h0000_A000, 5'd0, 2'b10);
    look(32'h0001_0100, 0, 2'b00, "R5 evict slot1");
    look(32'h0001_0200, 1, 2'b10, "R5 kept");
    inval(32'h0001_0300, 5'd0);
    refill(32'h0000_B000, 5'd0, 2'b01);
    look(32'h0000_B000, 1, 2'b01, "R5 free slot");
    look(32'h0001_0200, 1, 2'b10, "R5 free slot not evict");
    look(32'h0001_0300, 0, 2'b00, "R5 reused");
    refill(32'h0000_C000, 5'd0, 2'b01);
    look(32'h0001_0200, 0, 2'b00, "R5 rr slot2");
  endtask

  task automatic t_inv();
    flush();
    refill(32'h5000_0000, 5'd6, 2'b11);
    refill(32'h6000_0010, 5'd0, 2'b01);
    refill(32'h7000_0000, 5'd0, 2'b10);
    inval(32'h5000_0040, 5'd0);
    look(32'h5000_0000, 0, 2'b00, "R6 small key in big entry");
    look(32'h6000_0010, 1, 2'b01, "R6 disjoint kept");
    look(32'h7000_0000, 1, 2'b10, "R6 disjoint kept");
    inval(32'h6000_0000, 5'd4);
    look(32'h6000_0010, 0, 2'b00, "R6 big key over entry");
    look(32'h7000_0000, 1, 2'b10, "R6 kept");
    @(negedge clk);
    inv_word = 30'h1C00_0000; inv_ign = 5'd8; inv_valid = 1'b1;
    rf_word = 30'h1C00_0040; rf_ign = 5'd0; rf_perm = 2'b11; rf_valid = 1'b1;
    @(negedge clk);
    inv_valid = 1'b0; rf_valid = 1'b0;
    look(32'h7000_0000, 0, 2'b00, "R6 same-cycle cleared");
    look(32'h7000_0100, 1, 2'b11, "R6 refill survives");
  endtask

  task automatic t_flush();
    refill(32'h0000_D000, 5'd0, 2'b01);
    look(32'h0000_D000, 1, 2'b01, "R7 before");
    @(negedge clk);
    base_wr = 1'b1;
    rf_word = 30'h0000_3C00; rf_ign = 5'd0; rf_perm = 2'b10; rf_valid = 1'b1;
    @(negedge clk);
    base_wr = 1'b0; rf_valid = 1'b0;
    look(32'h0000_D000, 0, 2'b00, "R7 flushed");
    look(32'h0000_F000, 0, 2'b00, "R7 refill dropped");
    look(32'h7000_0100, 0, 2'b00, "R7 flushed");
  endtask

  task automatic t_prio();
    flush();
    refill(32'h3000_0000, 5'd4, 2'b10);
    refill(32'h3000_0008, 5'd0, 2'b01);
    look(32'h3000_0008, 1, 2'b10, "R8 lowest slot");
    inval(32'h3000_0020, 5'd0);
    refill(32'h3000_0008, 5'd0, 2'b11);
    look(32'h3000_0008, 1, 2'b11, "R8 lowest slot after swap");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_exact();
    t_region();
    t_walk();
    t_repl();
    t_inv();
    t_flush();
    t_prio();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule